// File: doc/BRIEF.md
# Three-Decade BCD Event Counter with Holding Latches

This block counts events on a single-bit count input using three decimal digits (units, tens, hundreds). Every digit is a register in the system clock domain. All three are updated on the same clock edge, so a carry ripples through every digit within a single counting event rather than one digit per event. The count input is sampled on the system clock. A falling transition seen between two samples is one counting event.

Each digit has a four-bit holding stage between the counter and the output. While the latch enable is low, the outputs show the live count. When the latch enable is raised, the outputs freeze at the count present at that moment and stay frozen until the enable drops. This holds even if counting continues or the counters are reset underneath. An inhibit input blocks counting events without disturbing the count.

A one-cycle overflow pulse marks every wrap from 999 to 000, so further counter stages can be chained on it.

Top module: `bcd_tri_counter`

## Requirements
- R1: A high-to-low transition of `count_in` adds one to the count. The new value appears on the outputs in the second clock cycle after the first clock edge that samples `count_in` low. A low-to-high transition changes nothing.
- R2: Each digit holds a BCD value from 0 to 9. A digit at 9 that receives an increment becomes 0 and carries into the next digit.
- R3: A carry reaches every digit on the same event. For example, 099 becomes 100, and 999 becomes 000, in one step.
- R4: While `inhibit` is high, counting events are dropped and the count is kept.
- R5: `mrst` high, sampled on a clock edge, clears all three digits to zero. It takes priority over counting.
- R6: While `latch_en` is low, `digits` shows the live count. `digits[3:0]` carries the units, `[7:4]` the tens and `[11:8]` the hundreds.
- R7: While `latch_en` is high, `digits` keeps the count that was present when `latch_en` rose, however many counting events arrive.
- R8: If `latch_en` stays high through a master reset, `digits` still shows the held value after the counters have cleared.
- R9: `overflow` is high for exactly one clock cycle on each 999-to-000 wrap. It is high in the same cycle that the counters first show 000, and it is never high otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| mrst | input | 1 | Master reset, active high, synchronous |
| count_in | input | 1 | Event input; each falling transition counts once |
| inhibit | input | 1 | High blocks counting events |
| latch_en | input | 1 | Low: outputs follow the count; high: outputs hold |
| digits | output | 12 | Three BCD digits, units in the low nibble |
| overflow | output | 1 | One-cycle pulse on each wrap past 999 |

## Verification
A falling edge on `count_in` that is first sampled at clock edge k shows up on the count and on `overflow` at edge k+1. The bench drives inputs on the falling clock edge and waits four falling edges after each event before it compares the digits. Over that same four-sample window it counts how many samples have `overflow` high, and expects exactly one sample on a wrap and none otherwise. `latch_en` steers the outputs without a register in between, so the hold and transparency checks sample one falling edge after the enable changes. The sweep runs past 1000 events, so every digit value, every carry pattern and one wrap are compared against expected values derived from the event count.

// File: rtl/bcd_tri_pkg.sv
package bcd_tri_pkg;
    localparam int DEFAULT_RADIX  = 10;
    localparam int DEFAULT_DIGITS = 3;

    typedef struct packed {
        logic smp;
        logic prev;
    } edge_state_t;
endpackage

// File: rtl/bcd_fall_detect.sv
module bcd_fall_detect
    import bcd_tri_pkg::*;
(
    input  logic clk,
    input  logic clr,
    input  logic sig_in,
    output logic fall
);
    edge_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.smp  = 1'b0;
            st_d.prev = 1'b0;
        end else begin
            st_d.smp  = sig_in;
            st_d.prev = st_q.smp;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign fall = st_q.prev & ~st_q.smp;

    // R1: an event never lasts two cycles in a row
    assert_fall_single_R1: assert property (@(posedge clk) disable iff (clr)
        fall |=> !fall);
endmodule

// File: rtl/bcd_decade.sv
module bcd_decade #(
    parameter int RADIX = 10,
    localparam int W = $clog2(RADIX)
) (
    input  logic         clk,
    input  logic         clr,
    input  logic         step,
    output logic [W-1:0] value,
    output logic [W-1:0] value_next,
    output logic         carry
);
    localparam logic [W-1:0] TOP = W'(RADIX - 1);

    logic [W-1:0] val_d, val_q;

    always_comb begin
        carry = step && (val_q == TOP);
        val_d = val_q;
        if (clr)
            val_d = '0;
        else if (carry)
            val_d = '0;
        else if (step)
            val_d = val_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        val_q <= val_d;
    end

    assign value      = val_q;
    assign value_next = val_d;

    // R2: digit stays within its radix
    assert_digit_range_R2: assert property (@(posedge clk) disable iff (clr)
        int'(val_q) < RADIX);
endmodule

// File: rtl/bcd_hold.sv
module bcd_hold #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         hold_en,
    input  logic [W-1:0] live,
    input  logic [W-1:0] live_next,
    output logic [W-1:0] shown
);
    logic [W-1:0] hold_d, hold_q;

    always_comb begin
        hold_d = hold_en ? hold_q : live_next;
        shown  = hold_en ? hold_q : live;
    end

    always_ff @(posedge clk) begin
        hold_q <= hold_d;
    end

    // R7: a held value does not move while the enable is high
    assert_hold_stable_R7: assert property (@(posedge clk)
        hold_en |=> $stable(hold_q));
endmodule

// File: rtl/bcd_tri_counter.sv
module bcd_tri_counter
    import bcd_tri_pkg::*;
#(
    parameter int RADIX      = DEFAULT_RADIX,
    parameter int NUM_DIGITS = DEFAULT_DIGITS,
    localparam int W         = $clog2(RADIX),
    localparam int BUS_W     = W * NUM_DIGITS
) (
    input  logic             clk,
    input  logic             mrst,
    input  logic             count_in,
    input  logic             inhibit,
    input  logic             latch_en,
    output logic [BUS_W-1:0] digits,
    output logic             overflow
);
    logic                  fall;
    logic [NUM_DIGITS:0]   step;
    logic [BUS_W-1:0]      cnt_all;
    logic [BUS_W-1:0]      cnt_next;
    logic                  ovf_d, ovf_q;

    bcd_fall_detect u_fall (
        .clk    (clk),
        .clr    (mrst),
        .sig_in (count_in),
        .fall   (fall)
    );

    assign step[0] = fall & ~inhibit;

    for (genvar gi = 0; gi < NUM_DIGITS; gi++) begin : g_digit
        bcd_decade #(.RADIX(RADIX)) u_dec (
            .clk        (clk),
            .clr        (mrst),
            .step       (step[gi]),
            .value      (cnt_all[gi*W +: W]),
            .value_next (cnt_next[gi*W +: W]),
            .carry      (step[gi+1])
        );

        bcd_hold #(.W(W)) u_hold (
            .clk       (clk),
            .hold_en   (latch_en),
            .live      (cnt_all[gi*W +: W]),
            .live_next (cnt_next[gi*W +: W]),
            .shown     (digits[gi*W +: W])
        );
    end

    always_comb begin
        ovf_d = mrst ? 1'b0 : step[NUM_DIGITS];
    end

    always_ff @(posedge clk) begin
        ovf_q <= ovf_d;
    end

    assign overflow = ovf_q;

    // R4: an inhibited cycle leaves the count unchanged
    assert_inhibit_keeps_R4: assert property (@(posedge clk) disable iff (mrst)
        (!mrst && inhibit) |=> $stable(cnt_all));

    // R5: the first cycle after reset shows a cleared count
    assert_reset_clears_R5: assert property (@(posedge clk) disable iff (mrst)
        $fell(mrst) |-> (cnt_all == '0));

    // R9: overflow coincides with an all-zero count
    assert_ovf_at_wrap_R9: assert property (@(posedge clk) disable iff (mrst)
        ovf_q |-> (cnt_all == '0));

    // R9: overflow lasts a single cycle
    assert_ovf_single_R9: assert property (@(posedge clk) disable iff (mrst)
        ovf_q |=> !ovf_q);
endmodule

// File: tb/bcd_tri_counter_bench.sv
module bcd_tri_counter_bench;
    logic        clk = 1'b0;
    logic        mrst = 1'b1;
    logic        count_in = 1'b0;
    logic        inhibit = 1'b0;
    logic        latch_en = 1'b0;
    logic [11:0] digits;
    logic        overflow;

    int vectors = 0;
    int misses  = 0;
    int ovf_seen;
    int count   = 0;

    always #4 clk = ~clk;

    bcd_tri_counter u_bcd_tri_counter (
        .clk      (clk),
        .mrst     (mrst),
        .count_in (count_in),
        .inhibit  (inhibit),
        .latch_en (latch_en),
        .digits   (digits),
        .overflow (overflow)
    );

    function automatic logic [11:0] to_bcd(input int n);
        int m;
        m = n % 1000;
        return {4'(m / 100), 4'((m / 10) % 10), 4'(m % 10)};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pulse();
        count_in = 1'b1;
        repeat (3) @(negedge clk);
        count_in = 1'b0;
        ovf_seen = 0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (overflow) ovf_seen++;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        mrst = 1'b0;
        @(negedge clk);
        // R5 reset state
        check("R5 reset digits", int'(digits), 0);
        check("R9 reset overflow", int'(overflow), 0);

        // R1: rising transition alone does not count
        count_in = 1'b1;
        repeat (4) @(negedge clk);
        check("R1 rising ignored", int'(digits), 0);
        count_in = 1'b0;
        repeat (4) @(negedge clk);
        count = 1;
        check("R1 falling counts", int'(digits), int'(to_bcd(count)));

        // R2 R3 R9 R6: sweep through a full wrap
        for (int i = 0; i < 1004; i++) begin
            pulse();
            count++;
            check("R2/R3 sweep count", int'(digits), int'(to_bcd(count)));
            check("R9 overflow pulses", ovf_seen, (count % 1000 == 0) ? 1 : 0);
        end

        // R4: inhibit blocks events
        inhibit = 1'b1;
        for (int i = 0; i < 5; i++) begin
            pulse();
            check("R4 inhibit keeps", int'(digits), int'(to_bcd(count)));
        end
        inhibit = 1'b0;

        // R7: hold while latch enable high
        latch_en = 1'b1;
        @(negedge clk);
        check("R7 captured", int'(digits), int'(to_bcd(count)));
        for (int i = 0; i < 3; i++) begin
            pulse();
            check("R7 hold while counting", int'(digits), int'(to_bcd(count)));
        end

        // R8: held value survives master reset
        mrst = 1'b1;
        repeat (2) @(negedge clk);
        mrst = 1'b0;
        @(negedge clk);
        check("R8 hold through reset", int'(digits), int'(to_bcd(count)));

        // R5 R6: release shows the cleared live count
        latch_en = 1'b0;
        @(negedge clk);
        check("R5/R6 cleared live", int'(digits), 0);
        count = 0;
        for (int i = 0; i < 2; i++) begin
            pulse();
            count++;
            check("R6 transparent", int'(digits), int'(to_bcd(count)));
        end

        // R5: reset has priority over an event in flight
        count_in = 1'b1;
        repeat (3) @(negedge clk);
        count_in = 1'b0;
        mrst = 1'b1;
        repeat (3) @(negedge clk);
        mrst = 1'b0;
        repeat (3) @(negedge clk);
        check("R5 reset over event", int'(digits), 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        misses++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule